// File: doc/BRIEF.md
# GPIO Pad Configuration Register File

This block holds the configuration of a bank of general-purpose I/O pads and makes it reachable over a plain 32-bit memory-mapped bus with an address, a write strobe, write data and combinational read data. Each pad owns two 32-bit control words. The first carries the sampled input level, the driven output level, a GPIO enable, a three-bit direction code, a four-bit function mode and a four-bit selector for one of sixteen shared interrupt lines. The second carries a three-bit trigger code, an input-inversion flag and a read-only configuration lock.

Pads are arranged in groups of fifteen. Each group occupies a 1 KiB window, and each pad takes an 8-byte slot inside that window. The block drives each pad's output level and its output and input enables from the stored fields. It passes each raw pad input through a two-stage synchronizer and then a capture flop before the value appears in the input-state bit. A lock strap, loaded only while reset is asserted, freezes a pad's configuration so that software can still toggle the output level but can change nothing else.

Top module: `gpio_padcfg_regs`

## Requirements
- R1: Word w (0 or 1) of pad p sits at byte address 0x4400 + 0x400*floor(p/15) + 8*(p mod 15) + 4*w. Only these addresses reach a pad.
- R2: After reset, word 0 of every pad reads 0x0000_0300 (direction code 3, all else zero) with bit 0 showing the captured input. Word 1 reads the pad's lock strap in bit 31 and zero elsewhere.
- R3: On an unlocked pad, a write to word 0 updates bit 1 (output level), bits 10:8 (direction), bit 15 (enable), bits 19:16 (mode) and bits 31:28 (interrupt line). All other bits of word 0 read zero, except bit 0.
- R4: On an unlocked pad, a write to word 1 updates bits 2:0 (trigger) and bit 6 (invert). All other bits of word 1 read zero, except bit 31.
- R5: Bit 31 of word 1 (lock) takes the value of that pad's lock_strap bit while rst_n is low. Bus writes never change it.
- R6: While a pad's lock is set, a write to its word 0 changes only bit 1, and a write to its word 1 changes nothing.
- R7: Word 0 bit 0 shows pad_in after a two-flop synchronizer and a capture flop. A level applied before rising edge k appears after edge k+2 and not after edge k+1.
- R8: pad_oe of a pad is 1 exactly when its enable is 1 and its direction code is 0 or 1. pad_ie is 1 exactly when its enable is 1 and its direction code is 0 or 2. Codes 3 to 7 release both.
- R9: pad_out of a pad always equals its word 0 bit 1.
- R10: An address below 0x4400, not word-aligned, in slot 15 of a group, or decoding to a pad index at or above NUM_PADS reads as zero, and writes to it change no pad.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; loads lock straps |
| bus_addr | input | ADDR_W | Byte address |
| bus_we | input | 1 | Write strobe, acted on at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lock_strap | input | NUM_PADS | Per-pad lock value captured during reset |
| pad_in | input | NUM_PADS | Raw pad input levels |
| pad_out | output | NUM_PADS | Output level to each pad |
| pad_oe | output | NUM_PADS | Output enable to each pad |
| pad_ie | output | NUM_PADS | Input enable to each pad |

## Verification
The hardest case to reach is a locked pad, because the lock can only come from the strap during reset. The bench therefore straps three pads, chosen at the first pad of a group, inside a group and the last pad, and then aims directed all-ones writes and many random writes at them. The edges of the grouped address map are also hard to reach at random, so directed accesses hit slot 15 of a group, misaligned offsets, the region below the base and pad indices past the last pad. After those accesses the bench reads back every pad to show that nothing moved. The input path is checked edge by edge to pin its three-flop latency.

// File: rtl/gpio_pad_pkg.sv
package gpio_pad_pkg;
  localparam int unsigned MAP_BASE    = 32'h4400;
  localparam int unsigned GRP_PADS    = 15;
  localparam int unsigned GRP_SHIFT   = 10;
  localparam int unsigned SLOT_SHIFT  = 3;
  localparam logic [31:0] W0_WR_MASK  = 32'hF00F_8702;
  localparam logic [31:0] W1_WR_MASK  = 32'h0000_0047;
  localparam logic [2:0]  DIR_RESET   = 3'd3;
  localparam int unsigned CFG_W       = 16;

  typedef struct packed {
    logic [3:0] isel;
    logic [3:0] mode;
    logic       en;
    logic [2:0] dir;
    logic [2:0] trig;
    logic       inv;
  } pad_cfg_t;

  function automatic int grp_slot_to_pad(input int grp, input int slot);
    return grp * GRP_PADS + slot;
  endfunction

  function automatic logic dir_drives(input logic en, input logic [2:0] dir);
    return en && (dir == 3'd0 || dir == 3'd1);
  endfunction

  function automatic logic dir_senses(input logic en, input logic [2:0] dir);
    return en && (dir == 3'd0 || dir == 3'd2);
  endfunction
endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PADS = 90,
  parameter int ADDR_W   = 16,
  localparam int PAD_W   = $clog2(NUM_PADS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [PAD_W-1:0]  pad_idx,
  output logic              word_sel
);
  logic [ADDR_W-1:0] off;
  logic              below;
  int                grp;
  int                slot;
  int                pad;

  always_comb begin
    below    = addr < ADDR_W'(MAP_BASE);
    off      = addr - ADDR_W'(MAP_BASE);
    grp      = int'(off >> GRP_SHIFT);
    slot     = int'(off[GRP_SHIFT-1:SLOT_SHIFT]);
    pad      = grp_slot_to_pad(grp, slot);
    word_sel = off[2];
    hit      = !below && (off[1:0] == 2'b00) && (slot < GRP_PADS) && (pad < NUM_PADS);
    pad_idx  = PAD_W'(pad);
  end
endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
  import gpio_pad_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap,
  input  logic        wr_w0,
  input  logic        wr_w1,
  input  logic [31:0] wdata,
  input  logic        pad_in,
  output logic [31:0] word0,
  output logic [31:0] word1,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        pad_ie,
  output logic        locked,
  output logic        rx_state,
  output pad_cfg_t    cfg_q
);
  pad_cfg_t   cfg;
  logic       tx;
  logic       lock;
  logic [1:0] sync;
  logic       rx;

  // Lock is a reset value only; the bus has no path to it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock <= strap;
    else        lock <= lock;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg     <= '0;
      cfg.dir <= DIR_RESET;
      tx      <= 1'b0;
    end else begin
      if (wr_w0) begin
        tx <= wdata[1];
        if (!lock) begin
          cfg.isel <= wdata[31:28];
          cfg.mode <= wdata[19:16];
          cfg.en   <= wdata[15];
          cfg.dir  <= wdata[10:8];
        end
      end
      if (wr_w1 && !lock) begin
        cfg.trig <= wdata[2:0];
        cfg.inv  <= wdata[6];
      end
    end
  end

  // Two synchronizer stages followed by the capture flop.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync <= '0;
      rx   <= 1'b0;
    end else begin
      sync <= {sync[0], pad_in};
      rx   <= sync[1];
    end
  end

  assign word0    = {cfg.isel, 8'b0, cfg.mode, cfg.en, 4'b0, cfg.dir, 6'b0, tx, rx};
  assign word1    = {lock, 24'b0, cfg.inv, 3'b0, cfg.trig};
  assign pad_out  = tx;
  assign pad_oe   = dir_drives(cfg.en, cfg.dir);
  assign pad_ie   = dir_senses(cfg.en, cfg.dir);
  assign locked   = lock;
  assign rx_state = rx;
  assign cfg_q    = cfg;
endmodule

// File: rtl/gpio_padcfg_regs.sv
module gpio_padcfg_regs
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PADS = 90,
  parameter int ADDR_W   = 16,
  localparam int PAD_W   = $clog2(NUM_PADS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PADS-1:0] lock_strap,
  input  logic [NUM_PADS-1:0] pad_in,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_ie
);
  logic                    acc_hit;
  logic [PAD_W-1:0]        acc_pad;
  logic                    acc_word;
  logic [31:0]             w0 [NUM_PADS];
  logic [31:0]             w1 [NUM_PADS];
  logic [NUM_PADS-1:0]     lock_vec;
  logic [NUM_PADS-1:0]     rx_vec;
  logic [NUM_PADS-1:0]     en_vec;
  pad_cfg_t [NUM_PADS-1:0] cfg_vec;

  gpio_addr_decode #(.NUM_PADS(NUM_PADS), .ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .hit(acc_hit), .pad_idx(acc_pad), .word_sel(acc_word)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
    logic sel;
    assign sel = acc_hit && (acc_pad == PAD_W'(i));

    gpio_pad_cell u_cell (
      .clk(clk), .rst_n(rst_n), .strap(lock_strap[i]),
      .wr_w0(bus_we && sel && !acc_word),
      .wr_w1(bus_we && sel && acc_word),
      .wdata(bus_wdata), .pad_in(pad_in[i]),
      .word0(w0[i]), .word1(w1[i]),
      .pad_out(pad_out[i]), .pad_oe(pad_oe[i]), .pad_ie(pad_ie[i]),
      .locked(lock_vec[i]), .rx_state(rx_vec[i]), .cfg_q(cfg_vec[i])
    );
    assign en_vec[i] = cfg_vec[i].en;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_PADS; i++)
      if (acc_hit && acc_pad == PAD_W'(i))
        bus_rdata = acc_word ? w1[i] : w0[i];
  end
endmodule

// File: rtl/gpio_padcfg_checker.sv
module gpio_padcfg_checker
  import gpio_pad_pkg::*;
#(
  parameter int NUM_PADS = 90
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    acc_hit,
  input logic [31:0]             bus_rdata,
  input logic [NUM_PADS-1:0]     pad_in,
  input logic [NUM_PADS-1:0]     pad_oe,
  input logic [NUM_PADS-1:0]     pad_ie,
  input logic [NUM_PADS-1:0]     en_vec,
  input logic [NUM_PADS-1:0]     lock_vec,
  input logic [NUM_PADS-1:0]     rx_vec,
  input pad_cfg_t [NUM_PADS-1:0] cfg_vec
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  p_miss_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_hit |-> bus_rdata == 32'h0);

  p_lock_constant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(lock_vec));

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_chk
    p_locked_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lock_vec[i] |=> $stable(cfg_vec[i]));

    p_disabled_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !en_vec[i] |-> !pad_oe[i] && !pad_ie[i]);

    p_input_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
      since_rst == 2'd3 |-> rx_vec[i] == $past(pad_in[i], 3));
  end
endmodule

bind gpio_padcfg_regs gpio_padcfg_checker #(.NUM_PADS(NUM_PADS)) u_checker (
  .clk(clk), .rst_n(rst_n), .acc_hit(acc_hit), .bus_rdata(bus_rdata),
  .pad_in(pad_in), .pad_oe(pad_oe), .pad_ie(pad_ie), .en_vec(en_vec),
  .lock_vec(lock_vec), .rx_vec(rx_vec), .cfg_vec(cfg_vec)
);

// File: tb/test_gpio_padcfg_regs.sv
`timescale 1ns/1ps
module test_gpio_padcfg_regs;
  localparam int N  = 90;
  localparam int AW = 16;
  localparam logic [N-1:0] LOCKS = (N'(1) << 3) | (N'(1) << 15) | (N'(1) << 89);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_ie;

  int errors = 0;
  int checks = 0;
  logic [31:0] m0 [N];
  logic [31:0] m1 [N];

  always #2.5 clk = ~clk;

  gpio_padcfg_regs #(.NUM_PADS(N), .ADDR_W(AW)) i_gpio_padcfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock_strap(LOCKS),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_ie(pad_ie)
  );

  // Address of a pad word: groups of fifteen, 1 KiB per group, 8 bytes per pad.
  function automatic logic [AW-1:0] where(input int p, input int w);
    int g, s;
    g = p / 15;
    s = p - g * 15;
    return AW'(32'h4400 + (g << 10) + (s << 3) + (w << 2));
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] d,
                                        input logic [31:0] m);
    return (old & ~m) | (d & m);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  // Model write following R3/R4/R6.
  task automatic model_wr(input int p, input int w, input logic [31:0] d);
    if (p >= N) return;
    if (w == 0) m0[p] = merge(m0[p], d, LOCKS[p] ? 32'h2 : 32'hF00F_8702);
    else if (!LOCKS[p]) m1[p] = merge(m1[p], d, 32'h47);
  endtask

  task automatic check_all(input string req);
    logic [31:0] v;
    for (int p = 0; p < N; p++) begin
      rd(where(p, 0), v);
      check(req, v, {m0[p][31:1], pad_in[p]});
      rd(where(p, 1), v);
      check(req, v, m1[p]);
    end
  endtask

  task automatic check_pins();
    logic [2:0] d;
    logic e;
    for (int p = 0; p < N; p++) begin
      d = m0[p][10:8];
      e = m0[p][15];
      check("R8 oe", 32'(pad_oe[p]), 32'(e && d <= 3'd1));
      check("R8 ie", 32'(pad_ie[p]), 32'(e && (d == 3'd0 || d == 3'd2)));
      check("R9 out", 32'(pad_out[p]), 32'(m0[p][1]));
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(1234));
    for (int p = 0; p < N; p++) begin
      m0[p] = 32'h0000_0300;
      m1[p] = {LOCKS[p], 31'b0};
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1, R2: reset image at every pad address.
    check_all("R2 reset");
    check_pins();

    // R10: misses read zero and touch nothing.
    wr(16'h4000, 32'hFFFF_FFFF);
    rd(16'h4000, v); check("R10 below base", v, 0);
    wr(16'h4478, 32'hFFFF_FFFF);
    rd(16'h4478, v); check("R10 slot15", v, 0);
    wr(16'h4401, 32'hFFFF_FFFF);
    rd(16'h4401, v); check("R10 misaligned", v, 0);
    wr(where(N, 0), 32'hFFFF_FFFF);
    rd(where(N, 0), v); check("R10 past last pad", v, 0);
    check_all("R10 no side effect");

    // R6, R5: all-ones at locked pads; R3, R4 at unlocked neighbours.
    for (int k = 0; k < 3; k++) begin
      int p;
      p = (k == 0) ? 3 : (k == 1) ? 15 : 89;
      wr(where(p, 0), 32'hFFFF_FFFF); model_wr(p, 0, 32'hFFFF_FFFF);
      wr(where(p, 1), 32'hFFFF_FFFF); model_wr(p, 1, 32'hFFFF_FFFF);
      rd(where(p, 0), v); check("R6 locked w0", v, 32'h0000_0302);
      rd(where(p, 1), v); check("R6 locked w1", v, 32'h8000_0000);
    end
    wr(where(4, 0), 32'hFFFF_FFFF); model_wr(4, 0, 32'hFFFF_FFFF);
    rd(where(4, 0), v); check("R3 unlocked w0", v, 32'hF00F_8702);
    wr(where(4, 1), 32'hFFFF_FFFF); model_wr(4, 1, 32'hFFFF_FFFF);
    rd(where(4, 1), v); check("R4 R5 unlocked w1", v, 32'h0000_0047);

    // R7: input latency, edge by edge.
    @(negedge clk) pad_in[20] = 1'b1;
    bus_addr = where(20, 0);
    @(posedge clk); @(posedge clk); #1;
    check("R7 not after 2 edges", 32'(bus_rdata[0]), 0);
    @(posedge clk); #1;
    check("R7 after 3 edges", 32'(bus_rdata[0]), 1);

    // Random pad input pattern and random accesses.
    for (int b = 0; b < N; b++) pad_in[b] = 1'($urandom);
    repeat (5) @(posedge clk);
    for (int i = 0; i < 1500; i++) begin
      int p, w;
      logic [31:0] d;
      p = $urandom_range(0, N + 4);
      w = $urandom_range(0, 1);
      d = $urandom;
      if ($urandom_range(0, 7) == 0) d[10:8] = 3'($urandom_range(0, 3));
      wr(where(p, w), d);
      model_wr(p, w, d);
      if (p < N && $urandom_range(0, 3) == 0) begin
        rd(where(p, w), v);
        check("R3 R4 R6 random", v, w == 0 ? {m0[p][31:1], pad_in[p]} : m1[p]);
      end
    end
    check_all("R1 R3 R4 R7 final");
    check_pins();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule